// File: doc/BRIEF.md
# Reference-Timed Data Rate Meter

This block measures the rate of a recovered data clock against a local reference clock. It opens a gate that lasts a fixed number of reference cycles. During that gate it counts recovered-clock events. At the close of the gate it stores the count as a ratio. The data rate is then `f_data = rate × f_ref / 2^(BASE_EXP + range_sel)`. The range code picks the gate length to suit the reference band: with the default exponent, codes 0, 1, 2 and 3 suit references of roughly 10–20, 20–40, 40–80 and 80–160 MHz. For example, a 32 MHz reference on code 1 with a 622.08 Mbps stream gives a count close to 0x9B851.

Both clocks reach the block as single-cycle enables (`ref_tick`, `data_tick`) in the system clock domain. The measurement enable is a level. While it stays high, every restart handshake starts a new measurement without enabling the block again. The restart handshake is `restart` driven high and then low. The result is also offered as three bytes for register readback. The result is flagged valid only while the loss-of-lock input is low. If lock is lost during a gate, that measurement is abandoned.

Top module: `drm_rate_meter`

## Requirements
- R1: A gate counts `ref_tick` pulses sampled while gating. It closes on the clock edge that samples the 2^(BASE_EXP+SEL)-th pulse. `rate` then holds the number of `data_tick` pulses sampled from the first gating cycle through the closing cycle, inclusive. Gating starts on the edge after the block sampled `meas_en` high while idle.
- R2: `range_sel` is sampled when the gate starts. Codes 0, 1, 2 and 3 select gates of 2^BASE_EXP, 2^(BASE_EXP+1), 2^(BASE_EXP+2) and 2^(BASE_EXP+3) reference pulses.
- R3: `meas_en` is level sensitive. While it is low, an idle block starts no gate. While it is high, an idle block starts a gate at once, so repeated measurements need only the restart handshake.
- R4: A restart takes effect on the edge that samples `restart` low after it was sampled high. That edge clears `done` and returns the block to idle. Holding `restart` high has no effect.
- R5: `done` is 0 after reset and while measuring, and becomes 1 on the edge that closes a gate.
- R6: `rate_hi` = {0, rate[22:16]}, `rate_mid` = rate[15:8] and `rate_lo` = rate[7:0]. Bits above CNT_W-1 read as 0.
- R7: `valid` is 1 exactly when `done` is 1 and `lol` is 0.
- R8: The event count saturates at 2^CNT_W−1 and does not wrap.
- R9: `rate` changes only on the edge that closes a gate. It is 0 after reset.
- R10: If `lol` is sampled high during a gate, the measurement is abandoned. `done` then stays 0 and `rate` keeps its previous value until a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One pulse per reference clock cycle |
| data_tick | input | 1 | One pulse per recovered data clock event |
| range_sel | input | SEL_W | Reference range code, selects gate length |
| meas_en | input | 1 | Measurement enable level |
| restart | input | 1 | Restart control, acts on high-then-low |
| lol | input | 1 | Loss-of-lock status |
| rate | output | CNT_W | Measured event count |
| rate_hi | output | 8 | Result bits 22..16, zero-extended |
| rate_mid | output | 8 | Result bits 15..8 |
| rate_lo | output | 8 | Result bits 7..0 |
| done | output | 1 | Measurement complete |
| valid | output | 1 | Result complete and lock held |

## Verification
Saturated tick streams on every range code pin each gate length to an exact count. This separates the four codes, and on the longest gate it exposes wrapping against saturation. Random densities of both ticks, from a fixed seed, test the inclusive gate boundaries: an off-by-one on the first or the closing cycle changes the count. Directed sequences cover the rest:
- holding `restart` high without releasing it;
- restarting with `meas_en` low;
- asserting `lol` during a gate and after completion.

These tell apart a falling-edge restart from a level restart, an aborted gate from a completed one, and `valid` from `done`.

// File: rtl/drm_pkg.sv
package drm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_GATE  = 2'd1,
      ST_DONE  = 2'd2,
      ST_ABORT = 2'd3
   } drm_state_e;

   localparam int PACK_W = 23;
endpackage

// File: rtl/drm_ctrl.sv
module drm_ctrl
   import drm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic meas_en,
   input  logic restart,
   input  logic lol,
   input  logic gate_end,
   output logic start,
   output logic active,
   output logic commit,
   output logic done
);
   drm_state_e st_q, st_d;
   logic       restart_q;
   logic       rst_pulse;

   assign rst_pulse = restart_q & ~restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) restart_q <= 1'b0;
      else        restart_q <= restart;
   end

   always_comb begin
      st_d   = st_q;
      start  = 1'b0;
      commit = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (rst_pulse)    st_d = ST_IDLE;
            else if (meas_en) begin
               st_d  = ST_GATE;
               start = 1'b1;
            end
         end
         ST_GATE: begin
            if (rst_pulse || !meas_en) st_d = ST_IDLE;
            else if (lol)              st_d = ST_ABORT;
            else if (gate_end) begin
               st_d   = ST_DONE;
               commit = 1'b1;
            end
         end
         default: if (rst_pulse) st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign active = (st_q == ST_GATE);
   assign done   = (st_q == ST_DONE);

   // R4: a completed restart handshake always clears the completion flag
   p_restart_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse |=> !done);

   // R10: loss of lock during a gate abandons it
   p_abort_on_lol_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (active && lol && meas_en && !rst_pulse) |=> (st_q == ST_ABORT));

   // R4: restart held high never leaves the completed state
   p_restart_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && restart && restart_q) |=> done);
endmodule

// File: rtl/drm_gate_timer.sv
module drm_gate_timer #(
   parameter int BASE_EXP = 14,
   parameter int SEL_W    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             active,
   input  logic             ref_tick,
   input  logic [SEL_W-1:0] range_sel,
   output logic             gate_end
);
   localparam int GATE_W = BASE_EXP + (1 << SEL_W);
   localparam logic [GATE_W-1:0] ONE = GATE_W'(1);

   logic [SEL_W-1:0]  sel_q;
   logic [GATE_W-1:0] ref_cnt;
   logic [GATE_W-1:0] last_idx;

   initial begin
      if (BASE_EXP < 1)
         $error("drm_gate_timer: BASE_EXP must be at least 1");
      if (SEL_W < 1 || SEL_W > 3)
         $error("drm_gate_timer: SEL_W must be 1 to 3");
   end

   always_comb last_idx = (ONE << (BASE_EXP + int'(sel_q))) - ONE;

   assign gate_end = active & ref_tick & (ref_cnt == last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= '0;
         ref_cnt <= '0;
      end else begin
         if (start) sel_q <= range_sel;
         if (!active || gate_end) ref_cnt <= '0;
         else if (ref_tick)       ref_cnt <= ref_cnt + ONE;
      end
   end

   // R1: the reference count never runs past the gate length
   p_gate_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (ref_cnt <= last_idx));

   // R2: the range code is frozen for the whole gate
   p_sel_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !start) |=> (!active || $stable(sel_q)));
endmodule

// File: rtl/drm_event_counter.sv
module drm_event_counter #(
   parameter int CNT_W = 23
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             active,
   input  logic             data_tick,
   output logic [CNT_W-1:0] cnt_next
);
   localparam logic [CNT_W-1:0] MAXV = '1;

   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      cnt_next = cnt_q;
      if (active && data_tick && cnt_q != MAXV) cnt_next = cnt_q + CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clear)  cnt_q <= '0;
      else if (active) cnt_q <= cnt_next;
   end

   // R8: once full, the count holds until cleared
   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == MAXV && !clear) |=> (cnt_q == MAXV));
endmodule

// File: rtl/drm_rate_meter.sv
module drm_rate_meter
   import drm_pkg::*;
#(
   parameter int CNT_W    = 23,
   parameter int BASE_EXP = 14,
   parameter int SEL_W    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_tick,
   input  logic             data_tick,
   input  logic [SEL_W-1:0] range_sel,
   input  logic             meas_en,
   input  logic             restart,
   input  logic             lol,
   output logic [CNT_W-1:0] rate,
   output logic [7:0]       rate_hi,
   output logic [7:0]       rate_mid,
   output logic [7:0]       rate_lo,
   output logic             done,
   output logic             valid
);
   logic             start, active, commit, gate_end;
   logic [CNT_W-1:0] cnt_next;
   logic [CNT_W-1:0] rate_q;
   logic [PACK_W-1:0] packed_rate;
   logic [7:0]        low_bytes [2];

   initial begin
      if (CNT_W < 1 || CNT_W > PACK_W)
         $error("drm_rate_meter: CNT_W must be 1 to 23");
   end

   drm_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .meas_en  (meas_en),
      .restart  (restart),
      .lol      (lol),
      .gate_end (gate_end),
      .start    (start),
      .active   (active),
      .commit   (commit),
      .done     (done)
   );

   drm_gate_timer #(.BASE_EXP(BASE_EXP), .SEL_W(SEL_W)) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .active    (active),
      .ref_tick  (ref_tick),
      .range_sel (range_sel),
      .gate_end  (gate_end)
   );

   drm_event_counter #(.CNT_W(CNT_W)) u_events (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (start),
      .active    (active),
      .data_tick (data_tick),
      .cnt_next  (cnt_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rate_q <= '0;
      else if (commit) rate_q <= cnt_next;
   end

   generate
      if (CNT_W < PACK_W) begin : g_pad
         assign packed_rate = {{(PACK_W-CNT_W){1'b0}}, rate_q};
      end else begin : g_full
         assign packed_rate = rate_q;
      end
      for (genvar b = 0; b < 2; b++) begin : g_byte
         assign low_bytes[b] = packed_rate[8*b +: 8];
      end
   endgenerate

   assign rate     = rate_q;
   assign rate_lo  = low_bytes[0];
   assign rate_mid = low_bytes[1];
   assign rate_hi  = {1'b0, packed_rate[22:16]};
   assign valid    = done & ~lol;

   // R9: the result moves only when a gate is committed
   p_result_atomic_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(rate_q));

   // R5: completion rises only from a committed gate
   p_done_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(commit));

   // R5: no completion while gating
   p_busy_not_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> !done);
endmodule

// File: tb/test_drm_rate_meter.sv
module test_drm_rate_meter;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 9;
   localparam int BASE_EXP   = 6;
   localparam int SEL_W      = 2;
   localparam int MAXV       = (1 << CNT_W) - 1;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             ref_tick, data_tick, meas_en, restart, lol;
   logic [SEL_W-1:0] range_sel;
   logic [CNT_W-1:0] rate;
   logic [7:0]       rate_hi, rate_mid, rate_lo;
   logic             done, valid;

   int  checks = 0;
   int  errors = 0;
   bit  finished = 0;
   int  last_rate = 0;

   drm_rate_meter #(.CNT_W(CNT_W), .BASE_EXP(BASE_EXP), .SEL_W(SEL_W)) i_drm_rate_meter (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .data_tick(data_tick),
      .range_sel(range_sel), .meas_en(meas_en), .restart(restart), .lol(lol),
      .rate(rate), .rate_hi(rate_hi), .rate_mid(rate_mid), .rate_lo(rate_lo),
      .done(done), .valid(valid)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int gate_len(input int sel);
      return 1 << (BASE_EXP + sel);
   endfunction

   function automatic int sat_count(input int n);
      return (n > MAXV) ? MAXV : n;
   endfunction

   task automatic check_bytes(input int v);
      chk("R6", "rate_hi", int'(rate_hi), (v >> 16) & 127);
      chk("R6", "rate_mid", int'(rate_mid), (v >> 8) & 255);
      chk("R6", "rate_lo", int'(rate_lo), v & 255);
   endtask

   // Called at a falling edge; the next rising edge is the gate start edge.
   task automatic gate_body(input int sel, input int ref_pct, input int data_pct,
                            input int abort_at, output int ndata, output bit aborted);
      int nref = 0;
      int it   = 0;
      ndata   = 0;
      aborted = 0;
      ref_tick = 0; data_tick = 0;
      @(posedge clk);
      while (nref < gate_len(sel)) begin
         @(negedge clk);
         if (it == 2) begin
            chk("R5", "done while gating", int'(done), 0);
            chk("R9", "rate held while gating", int'(rate), last_rate);
         end
         if (it == abort_at) lol = 1;
         ref_tick  = ($urandom_range(99) < ref_pct);
         data_tick = ($urandom_range(99) < data_pct);
         nref  += int'(ref_tick);
         ndata += int'(data_tick);
         @(posedge clk);
         if (it == abort_at) begin
            aborted = 1;
            break;
         end
         it++;
      end
      @(negedge clk);
      ref_tick = 0; data_tick = 0;
   endtask

   // Ends at a falling edge just after the restart took effect.
   task automatic restart_hs(input int hold);
      @(negedge clk);
      restart = 1;
      repeat (hold) @(negedge clk);
      restart = 0;
      @(negedge clk);
      chk("R4", "done cleared by restart", int'(done), 0);
   endtask

   task automatic measure(input string req, input int sel, input int rp, input int dp);
      int  n;
      bit  ab;
      range_sel = SEL_W'(sel);
      gate_body(sel, rp, dp, -1, n, ab);
      chk("R5", "done after gate", int'(done), 1);
      chk(req, "rate", int'(rate), sat_count(n));
      check_bytes(int'(rate));
      last_rate = int'(rate);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 0; ref_tick = 0; data_tick = 0; meas_en = 0; restart = 0; lol = 0;
      range_sel = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R5", "done after reset", int'(done), 0);
      chk("R9", "rate after reset", int'(rate), 0);
      chk("R7", "valid after reset", int'(valid), 0);

      // First measurement, R1 exact count with full-density ticks
      meas_en = 1;
      measure("R1", 1, 100, 100);
      chk("R1", "full density count", int'(rate), gate_len(1));
      chk("R7", "valid when done and locked", int'(valid), 1);

      // R2: each range code with saturated ticks; code 3 also saturates (R8)
      for (int s = 0; s < 4; s++) begin
         restart_hs(1);
         measure("R2", s, 100, 100);
      end
      chk("R8", "saturated count", int'(rate), MAXV);
      chk("R6", "saturated mid byte", int'(rate_mid), 1);

      // R1 with random densities
      for (int k = 0; k < 8; k++) begin
         restart_hs(1);
         measure("R1", k % 4, 40 + int'($urandom_range(60)), int'($urandom_range(100)));
      end

      // R7: lock loss after completion
      @(negedge clk);
      lol = 1;
      #1;
      chk("R7", "valid with lol", int'(valid), 0);
      chk("R7", "done kept with lol", int'(done), 1);
      lol = 0;
      #1;
      chk("R7", "valid after lol clears", int'(valid), 1);

      // R4: restart held high has no effect
      @(negedge clk);
      restart = 1;
      repeat (10) @(negedge clk);
      chk("R4", "done with restart held", int'(done), 1);
      restart = 0;
      @(negedge clk);
      chk("R4", "done after release", int'(done), 0);
      measure("R3", 2, 70, 50);

      // R10: abort on lock loss
      begin
         int  n;
         bit  ab;
         restart_hs(1);
         range_sel = 2'd3;
         gate_body(3, 80, 80, 5, n, ab);
         chk("R10", "aborted flag", int'(ab), 1);
         chk("R10", "done after abort", int'(done), 0);
         chk("R10", "rate kept after abort", int'(rate), last_rate);
         lol = 0;
         repeat (600) @(negedge clk);
         chk("R10", "done stays 0 after abort", int'(done), 0);
         chk("R10", "rate still kept", int'(rate), last_rate);
      end
      restart_hs(1);
      measure("R10", 0, 90, 60);

      // R3: enable low blocks new gates
      meas_en = 0;
      restart_hs(2);
      for (int c = 0; c < 700; c++) begin
         @(negedge clk);
         ref_tick = 1;
         data_tick = $urandom_range(1);
      end
      @(negedge clk);
      ref_tick = 0; data_tick = 0;
      chk("R3", "no gate while disabled", int'(done), 0);
      chk("R3", "rate unchanged while disabled", int'(rate), last_rate);
      meas_en = 1;
      measure("R3", 1, 60, 90);

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule